// File: doc/BRIEF.md
# DMA Channel Register File

This block is the software-visible register file of a small multi-channel DMA controller. A bus master reaches it through a single-cycle request port: valid, write, byte address and write data. The block answers every request on the next clock with a response strobe, read data and an error flag. Registers are split into two regions. The global region sits below a channel base offset. Above that base, one equal-sized window per channel holds eight word registers.

Every stored value is driven out continuously to the transfer engine. The engine writes status back through per-channel set and clear masks on the channel control/status word, and through set masks on the two interrupt source words.

Two rules govern the channel control/status word. A bus write changes only a fixed group of writable bits. A bus read returns the word and then clears its error and interrupt flags. Status driven by the engine in the same cycle overrides both rules.

Top module: `dma_regfile`

## Requirements
- R1: After reset every register reads 0, except each channel's source mask (channel word 3, offset 0x0C) and destination mask (channel word 5, offset 0x14), which read 0xFFFFFFFC.
- R2: Byte offsets below 0x20 are global: 0x00 control, 0x04 interrupt mask A, 0x08 interrupt mask B, 0x0C interrupt source A, 0x10 interrupt source B. Channel c occupies 0x20+0x20·c for c = 0..3. Within a channel window, word k sits at offset 4·k, in this order: control/status, size, source address, source mask, destination address, destination mask, descriptor pointer, software pointer. A legal write followed by a read returns the written value, except for the control words.
- R3: A request is rejected if its offset has a nonzero low two bits, falls at 0x14–0x1C, or is 0xA0 or above. A rejected request raises rsp_err for exactly one cycle, returns rsp_rdata 0 and changes no register.
- R4: Each cycle with bus_valid high is followed by exactly one cycle of rsp_valid. rsp_valid stays low one cycle after a cycle without a request.
- R5: A write to a channel control/status word changes only the bits in mask 0x8C7F (bits 0–6, 10, 11, 15). All other bits keep their value.
- R6: A read of a channel control/status word returns the value it held before the read. Bits 9, 12, 13 and 14 (mask 0x7200) are then cleared, and the other bits are kept.
- R7: The engine set mask for a channel forces bits to 1 and its clear mask forces bits to 0, in the same cycle. Set wins over clear, and both win over a bus write or read-clear in that cycle.
- R8: The global control word ignores every write, including the pause bit (bit 0), and always reads 0.
- R9: Bits in the engine's interrupt source set masks are ORed into interrupt source A/B. This includes the cycle of a bus write to that word, where the engine bits are ORed onto the written value.
- R10: Output buses carry each channel's eight words (channel c in bits 32·c+31..32·c) and the four global mask/source words at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data (0 for writes and rejects) |
| eng_csr_set | input | 32·NUM_CH | Engine bit-set masks for the channel control words |
| eng_csr_clr | input | 32·NUM_CH | Engine bit-clear masks for the channel control words |
| eng_src_a_set | input | 32 | Engine bits ORed into interrupt source A |
| eng_src_b_set | input | 32 | Engine bits ORed into interrupt source B |
| int_msk_a | output | 32 | Interrupt mask A |
| int_msk_b | output | 32 | Interrupt mask B |
| int_src_a | output | 32 | Interrupt source A |
| int_src_b | output | 32 | Interrupt source B |
| ch_csr | output | 32·NUM_CH | Channel control/status words |
| ch_size | output | 32·NUM_CH | Channel size words |
| ch_src_addr | output | 32·NUM_CH | Channel source addresses |
| ch_src_mask | output | 32·NUM_CH | Channel source masks |
| ch_dst_addr | output | 32·NUM_CH | Channel destination addresses |
| ch_dst_mask | output | 32·NUM_CH | Channel destination masks |
| ch_desc | output | 32·NUM_CH | Channel descriptor pointers |
| ch_swptr | output | 32·NUM_CH | Channel software pointers |

## Verification
The bench reads every aligned offset in the 256-byte space right after reset. That sweep separates the mask defaults from zeroed words and legal offsets from holes. It then writes a different offset-derived pattern to every offset and reads all of them back. The readback exposes decode aliasing between channels and words, as well as writes that leak into the control words or rejected slots. A sweep over all misaligned offsets confirms that each is rejected and leaves the register file untouched. Targeted sequences pit engine set and clear masks against bus writes and read-clears in the same cycle to show which source wins.

// File: rtl/dma_regfile.sv
module dma_regfile #(
  parameter int          NUM_CH    = 4,
  parameter int          ADDR_W    = 8,
  parameter int          CH_BASE   = 32,
  parameter int          CH_STRIDE = 32,
  parameter logic [31:0] CSR_WMASK = 32'h0000_8C7F,
  parameter logic [31:0] CSR_RCLR  = 32'h0000_7200,
  parameter logic [31:0] MASK_RST  = 32'hFFFF_FFFC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_valid,
  input  logic                 bus_write,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  input  logic [NUM_CH*32-1:0] eng_csr_set,
  input  logic [NUM_CH*32-1:0] eng_csr_clr,
  input  logic [31:0]          eng_src_a_set,
  input  logic [31:0]          eng_src_b_set,
  output logic [31:0]          int_msk_a,
  output logic [31:0]          int_msk_b,
  output logic [31:0]          int_src_a,
  output logic [31:0]          int_src_b,
  output logic [NUM_CH*32-1:0] ch_csr,
  output logic [NUM_CH*32-1:0] ch_size,
  output logic [NUM_CH*32-1:0] ch_src_addr,
  output logic [NUM_CH*32-1:0] ch_src_mask,
  output logic [NUM_CH*32-1:0] ch_dst_addr,
  output logic [NUM_CH*32-1:0] ch_dst_mask,
  output logic [NUM_CH*32-1:0] ch_desc,
  output logic [NUM_CH*32-1:0] ch_swptr
);
  localparam int NREG = 8;
  localparam int NGLB = 5;

  logic [31:0]       creg [NUM_CH][NREG];
  logic [31:0]       csr_n [NUM_CH];
  logic [31:0]       src_a_n, src_b_n, rd_mux;
  logic [ADDR_W-1:0] off, chn, sub;
  logic [2:0]        ridx;
  logic              glob, legal, wr, rd;

  assign glob  = bus_addr < ADDR_W'(CH_BASE);
  assign off   = bus_addr - ADDR_W'(CH_BASE);
  assign chn   = off / ADDR_W'(CH_STRIDE);
  assign sub   = off % ADDR_W'(CH_STRIDE);
  assign ridx  = glob ? bus_addr[4:2] : sub[4:2];
  assign legal = (bus_addr[1:0] == 2'b00) &&
                 (glob ? (ridx < 3'(NGLB))
                       : (chn < ADDR_W'(NUM_CH)) && (sub < ADDR_W'(NREG*4)));
  assign wr = bus_valid & bus_write & legal;
  assign rd = bus_valid & ~bus_write & legal;

  always_comb begin
    rd_mux = '0;
    if (glob) begin
      case (ridx)
        3'd1: rd_mux = int_msk_a;
        3'd2: rd_mux = int_msk_b;
        3'd3: rd_mux = int_src_a;
        3'd4: rd_mux = int_src_b;
        default: rd_mux = '0;
      endcase
    end else begin
      for (int c = 0; c < NUM_CH; c++)
        if (chn == ADDR_W'(c)) rd_mux = creg[c][ridx];
    end
  end

  always_comb begin
    src_a_n = (wr && glob && ridx == 3'd3) ? bus_wdata : int_src_a;
    src_b_n = (wr && glob && ridx == 3'd4) ? bus_wdata : int_src_b;
    src_a_n = src_a_n | eng_src_a_set;
    src_b_n = src_b_n | eng_src_b_set;
    for (int c = 0; c < NUM_CH; c++) begin
      csr_n[c] = creg[c][0];
      if (!glob && chn == ADDR_W'(c) && ridx == 3'd0) begin
        if (wr) csr_n[c] = (csr_n[c] & ~CSR_WMASK) | (bus_wdata & CSR_WMASK);
        if (rd) csr_n[c] = csr_n[c] & ~CSR_RCLR;
      end
      csr_n[c] = (csr_n[c] & ~eng_csr_clr[c*32 +: 32]) | eng_csr_set[c*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      int_msk_a <= '0;
      int_msk_b <= '0;
      int_src_a <= '0;
      int_src_b <= '0;
      for (int c = 0; c < NUM_CH; c++)
        for (int r = 0; r < NREG; r++)
          creg[c][r] <= (r == 3 || r == 5) ? MASK_RST : 32'h0;
    end else begin
      rsp_valid <= bus_valid;
      rsp_err   <= bus_valid & ~legal;
      rsp_rdata <= rd ? rd_mux : 32'h0;
      if (wr && glob && ridx == 3'd1) int_msk_a <= bus_wdata;
      if (wr && glob && ridx == 3'd2) int_msk_b <= bus_wdata;
      int_src_a <= src_a_n;
      int_src_b <= src_b_n;
      for (int c = 0; c < NUM_CH; c++) begin
        creg[c][0] <= csr_n[c];
        for (int r = 1; r < NREG; r++)
          if (wr && !glob && chn == ADDR_W'(c) && ridx == 3'(r))
            creg[c][r] <= bus_wdata;
      end
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_out
    assign ch_csr[g*32 +: 32]      = creg[g][0];
    assign ch_size[g*32 +: 32]     = creg[g][1];
    assign ch_src_addr[g*32 +: 32] = creg[g][2];
    assign ch_src_mask[g*32 +: 32] = creg[g][3];
    assign ch_dst_addr[g*32 +: 32] = creg[g][4];
    assign ch_dst_mask[g*32 +: 32] = creg[g][5];
    assign ch_desc[g*32 +: 32]     = creg[g][6];
    assign ch_swptr[g*32 +: 32]    = creg[g][7];
  end
endmodule

module dma_regfile_chk #(
  parameter int          NUM_CH    = 4,
  parameter int          ADDR_W    = 8,
  parameter int          CH_BASE   = 32,
  parameter logic [31:0] CSR_WMASK = 32'h0000_8C7F,
  parameter logic [31:0] CSR_RCLR  = 32'h0000_7200
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_valid,
  input logic                 bus_write,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 rsp_valid,
  input logic                 rsp_err,
  input logic [31:0]          rsp_rdata,
  input logic [NUM_CH*32-1:0] eng_csr_set,
  input logic [NUM_CH*32-1:0] eng_csr_clr,
  input logic [NUM_CH*32-1:0] ch_csr
);
  logic csr0_hit;
  assign csr0_hit = bus_valid && (bus_addr == ADDR_W'(CH_BASE));

  a_r4_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |=> rsp_valid);
  a_r4_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> !rsp_valid);
  a_r3_misaligned_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_addr[1:0] != 2'b00) |=> (rsp_err && rsp_rdata == 32'h0));
  a_r3_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_rdata == 32'h0));
  a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (csr0_hit && !bus_write && (eng_csr_set[31:0] & CSR_RCLR) == 32'h0)
      |=> (ch_csr[31:0] & CSR_RCLR) == 32'h0);
  a_r5_write_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (csr0_hit && bus_write && eng_csr_set[31:0] == 32'h0 && eng_csr_clr[31:0] == 32'h0)
      |=> (ch_csr[31:0] & ~CSR_WMASK) == $past(ch_csr[31:0] & ~CSR_WMASK));
  a_r7_engine_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_csr_set[31:0] != 32'h0)
      |=> (ch_csr[31:0] & $past(eng_csr_set[31:0])) == $past(eng_csr_set[31:0]));
endmodule

bind dma_regfile dma_regfile_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_BASE(CH_BASE),
  .CSR_WMASK(CSR_WMASK), .CSR_RCLR(CSR_RCLR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .eng_csr_set(eng_csr_set), .eng_csr_clr(eng_csr_clr),
  .ch_csr(ch_csr)
);

// File: tb/dma_regfile_bench.sv
module dma_regfile_bench;
  localparam int NCH = 4;
  localparam logic [31:0] WM = 32'h0000_8C7F;
  localparam logic [31:0] RC = 32'h0000_7200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic              bus_valid = 0, bus_write = 0;
  logic [7:0]        bus_addr = 0;
  logic [31:0]       bus_wdata = 0;
  logic              rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [NCH*32-1:0] eng_csr_set = '0, eng_csr_clr = '0;
  logic [31:0]       eng_src_a_set = 0, eng_src_b_set = 0;
  logic [31:0]       int_msk_a, int_msk_b, int_src_a, int_src_b;
  logic [NCH*32-1:0] ch_csr, ch_size, ch_src_addr, ch_src_mask;
  logic [NCH*32-1:0] ch_dst_addr, ch_dst_mask, ch_desc, ch_swptr;

  dma_regfile u_dma_regfile (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .eng_csr_set(eng_csr_set),
    .eng_csr_clr(eng_csr_clr), .eng_src_a_set(eng_src_a_set),
    .eng_src_b_set(eng_src_b_set), .int_msk_a(int_msk_a), .int_msk_b(int_msk_b),
    .int_src_a(int_src_a), .int_src_b(int_src_b), .ch_csr(ch_csr),
    .ch_size(ch_size), .ch_src_addr(ch_src_addr), .ch_src_mask(ch_src_mask),
    .ch_dst_addr(ch_dst_addr), .ch_dst_mask(ch_dst_mask), .ch_desc(ch_desc),
    .ch_swptr(ch_swptr)
  );

  int errs = 0, checks = 0;
  logic [31:0] mdl [64];
  logic [31:0] rdv, base;
  logic        erv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit legal(input logic [7:0] a);
    return a[1:0] == 2'b00 && (a < 8'h20 ? a < 8'h14 : a < 8'hA0);
  endfunction

  function automatic bit is_csr(input logic [7:0] a);
    return a >= 8'h20 && a < 8'hA0 && a[4:0] == 5'h0;
  endfunction

  task automatic acc(output logic [31:0] rdo, output logic ero,
                     input bit wr, input logic [7:0] a, input logic [31:0] d,
                     input int ch = 0, input logic [31:0] es = 0,
                     input logic [31:0] ec = 0, input logic [31:0] sa = 0);
    @(negedge clk);
    bus_valid = 1; bus_write = wr; bus_addr = a; bus_wdata = d;
    eng_csr_set[ch*32 +: 32] = es; eng_csr_clr[ch*32 +: 32] = ec; eng_src_a_set = sa;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
    eng_csr_set = '0; eng_csr_clr = '0; eng_src_a_set = 0;
    rdo = rsp_rdata; ero = rsp_err;
    chk("R4 rsp_valid", {31'b0, rsp_valid}, 32'h1);
  endtask

  task automatic eng(input int ch, input logic [31:0] es, input logic [31:0] ec,
                     input logic [31:0] sb);
    @(negedge clk);
    eng_csr_set[ch*32 +: 32] = es; eng_csr_clr[ch*32 +: 32] = ec; eng_src_b_set = sb;
    @(negedge clk);
    eng_csr_set = '0; eng_csr_clr = '0; eng_src_b_set = 0;
  endtask

  task automatic read_sweep(input string req);
    for (int i = 0; i < 64; i++) begin
      logic [7:0] a;
      a = 8'(i * 4);
      acc(rdv, erv, 1'b0, a, 32'h0);
      chk({req, " rdata"}, rdv, legal(a) ? mdl[i] : 32'h0);
      chk("R3 err flag", {31'b0, erv}, {31'b0, !legal(a)});
      if (is_csr(a)) mdl[i] = mdl[i] & ~RC;
    end
  endtask

  task automatic port_sweep(input string req);
    for (int c = 0; c < NCH; c++) begin
      int w;
      w = 8 + 8 * c;
      chk({req, " ch_csr"},      ch_csr[c*32 +: 32],      mdl[w]);
      chk({req, " ch_size"},     ch_size[c*32 +: 32],     mdl[w+1]);
      chk({req, " ch_src_addr"}, ch_src_addr[c*32 +: 32], mdl[w+2]);
      chk({req, " ch_src_mask"}, ch_src_mask[c*32 +: 32], mdl[w+3]);
      chk({req, " ch_dst_addr"}, ch_dst_addr[c*32 +: 32], mdl[w+4]);
      chk({req, " ch_dst_mask"}, ch_dst_mask[c*32 +: 32], mdl[w+5]);
      chk({req, " ch_desc"},     ch_desc[c*32 +: 32],     mdl[w+6]);
      chk({req, " ch_swptr"},    ch_swptr[c*32 +: 32],    mdl[w+7]);
    end
    chk({req, " int_msk_a"}, int_msk_a, mdl[1]);
    chk({req, " int_msk_b"}, int_msk_b, mdl[2]);
    chk({req, " int_src_a"}, int_src_a, mdl[3]);
    chk({req, " int_src_b"}, int_src_b, mdl[4]);
  endtask

  initial begin
    #(20ns * 150000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);
    chk("R1 idle rsp_err", {31'b0, rsp_err}, 32'h0);

    for (int i = 0; i < 64; i++) begin
      logic [7:0] a;
      a = 8'(i * 4);
      mdl[i] = (a >= 8'h20 && a < 8'hA0 && (a[4:0] == 5'h0C || a[4:0] == 5'h14))
               ? 32'hFFFF_FFFC : 32'h0;
    end
    port_sweep("R1 reset ports");
    read_sweep("R1 reset read");

    for (int i = 0; i < 64; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      a = 8'(i * 4);
      d = {a, ~a, a ^ 8'h3C, 8'h5A};
      acc(rdv, erv, 1'b1, a, d);
      chk("R3 write err", {31'b0, erv}, {31'b0, !legal(a)});
      chk("R2 write rdata", rdv, 32'h0);
      if (legal(a)) begin
        if (a == 8'h00) mdl[i] = mdl[i];
        else if (is_csr(a)) mdl[i] = (mdl[i] & ~WM) | (d & WM);
        else mdl[i] = d;
      end
    end
    port_sweep("R10 ports after writes");
    read_sweep("R2 readback");

    for (int a = 0; a < 256; a++) begin
      if (a[1:0] != 2'b00) begin
        acc(rdv, erv, a[2], 8'(a), 32'hFFFF_FFFF);
        chk("R3 misaligned err", {31'b0, erv}, 32'h1);
        chk("R3 misaligned rdata", rdv, 32'h0);
      end
    end
    read_sweep("R3 unchanged after rejects");

    acc(rdv, erv, 1'b1, 8'h00, 32'hFFFF_FFFF);
    acc(rdv, erv, 1'b0, 8'h00, 32'h0);
    chk("R8 global control reads zero", rdv, 32'h0);
    chk("R8 global control no error", {31'b0, erv}, 32'h0);

    base = mdl[16];
    eng(1, 32'h0000_7380, 32'h0, 32'h0);
    chk("R7 engine set visible", ch_csr[63:32], base | 32'h7380);
    acc(rdv, erv, 1'b0, 8'h40, 32'h0);
    chk("R6 read returns pre-clear", rdv, base | 32'h7380);
    chk("R6 bits cleared after read", ch_csr[63:32], base | 32'h0180);
    acc(rdv, erv, 1'b0, 8'h40, 32'h0, 1, 32'h0000_0200);
    chk("R7 set beats read-clear", ch_csr[63:32], base | 32'h0380);
    acc(rdv, erv, 1'b1, 8'h40, 32'h0000_0001, 1, 32'h0, 32'h0000_0001);
    chk("R7 clear beats write", ch_csr[63:32], 32'h0000_0380);
    eng(1, 32'h0000_0004, 32'h0000_0004, 32'h0);
    chk("R7 set beats clear", ch_csr[63:32], 32'h0000_0384);

    eng(2, 32'h0000_0100, 32'h0, 32'h0);
    acc(rdv, erv, 1'b1, 8'h60, 32'h0);
    chk("R5 write zero keeps status", ch_csr[95:64], 32'h0000_0100);
    acc(rdv, erv, 1'b1, 8'h60, 32'hFFFF_FFFF);
    chk("R5 write ones masked", ch_csr[95:64], 32'h0000_8D7F);

    acc(rdv, erv, 1'b1, 8'h0C, 32'h0000_00F0, 0, 32'h0, 32'h0, 32'h0000_0001);
    acc(rdv, erv, 1'b0, 8'h0C, 32'h0);
    chk("R9 src A write plus engine", rdv, 32'h0000_00F1);
    acc(rdv, erv, 1'b1, 8'h10, 32'h0);
    eng(0, 32'h0, 32'h0, 32'h0000_0810);
    chk("R9 src B engine OR", int_src_b, 32'h0000_0810);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule